// File: doc/BRIEF.md
# PSRAM Configuration Register Sequencer

This block carries out configuration-register transfers to pseudo-static RAM devices that hang off a 16-bit host bus with address and data multiplexed on the same pins. Software loads a single shared holding register with a configuration word. It then raises a write-request or a read-request bit for one of four chip-select slots. The sequencer asserts the configuration-enable strobe and the selected chip select, and runs a short multiplexed bus cycle. On a write, that cycle drives the holding value into the memory. On a read, it captures the memory's configuration word back into the holding register.

Request bits from several slots may be pending together. They are served one transfer at a time, and each request bit clears itself when its transfer ends. While any configuration work is pending or in flight, the block reports busy and refuses grants to ordinary system accesses. Requests are only taken while the bus is configured for multiplexed 16-bit operation.

Top module: `psram_cfg_seq`

## Requirements
- R1: During and right after a synchronous reset, every chip select, the read strobe and the write strobe are high. The enable strobe, address latch, bus output enable, busy and done are low. The holding register and all request bits are zero.
- R2: A request-set input is ignored while `mux_mode_i` is low: no request bit is set, busy stays low, and no bus cycle starts.
- R3: A request in slot i drives `bus_cs_n_o[i]` low and no other chip select. At most one chip select is low at any time, and only while a transfer is running.
- R4: `bus_cre_o` is high in exactly the cycles in which a chip select is low, covering the address, turnaround and data phases of a transfer.
- R5: A transfer starts in the cycle after its request bit is seen pending. It has one address cycle (latch high, pins driven with the fixed register address `CFG_ADDR`, default 16'h0080), one turnaround cycle with the pins released, and `DATA_CYC` data cycles (default 2) with the write or the read strobe low. It ends with one release cycle in which every strobe and chip select is inactive.
- R6: During the data phase of a write transfer, the pins are driven with the holding-register value.
- R7: A read transfer loads the value on `bus_ad_i` at the clock edge ending its last data cycle into the holding register.
- R8: The completed transfer's request bit (write or read) clears at the edge that ends the data phase. `done_o` is high for exactly the following release cycle.
- R9: Pending requests are served in order of slot index, 0 first. Within one slot, the write goes before the read.
- R10: `busy_o` is high from the cycle after a request bit is set until the release cycle of the last pending transfer, inclusive.
- R11: `sys_gnt_o` equals `sys_req_i` while the block is not busy, and is low whenever busy is high.
- R12: A holding-register write presented while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mux_mode_i | input | 1 | High when the bus runs in 16-bit multiplexed mode |
| hold_we_i | input | 1 | Write strobe for the holding register |
| hold_wdata_i | input | 16 | Value written into the holding register |
| hold_o | output | 16 | Holding register contents |
| wr_req_set_i | input | 4 | Per-slot pulse that sets the write-request bit |
| rd_req_set_i | input | 4 | Per-slot pulse that sets the read-request bit |
| wr_pend_o | output | 4 | Pending write-request bits |
| rd_pend_o | output | 4 | Pending read-request bits |
| busy_o | output | 1 | Configuration work pending or in flight |
| done_o | output | 1 | One-cycle pulse after each transfer |
| sys_req_i | input | 1 | Ordinary system access request |
| sys_gnt_o | output | 1 | Grant for the ordinary access |
| bus_ad_o | output | 16 | Multiplexed address/data out |
| bus_ad_oe_o | output | 1 | Output enable for the multiplexed pins |
| bus_ad_i | input | 16 | Multiplexed address/data in |
| bus_ale_o | output | 1 | Address latch enable |
| bus_rd_n_o | output | 1 | Active-low read strobe |
| bus_wr_n_o | output | 1 | Active-low write strobe |
| bus_cs_n_o | output | 4 | Active-low chip selects |
| bus_cre_o | output | 1 | Configuration-register enable strobe |

## Verification
A single write on slot 0 and a single read on slot 2 establish the basic phase sequence and each direction on its own. The read-data input changes on every cycle, so only a capture at the exact closing edge gives the right value. A burst that sets four requests across three slots in one cycle separates slot order from write-before-read order. Requests raised outside multiplexed mode, holding writes made during a transfer, and system requests made both while busy and while idle show, at the ports, the stimuli that must leave no trace apart from those that must take effect.

// File: rtl/psram_cfg_pkg.sv
package psram_cfg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_TURN = 3'd2,
    PH_DATA = 3'd3,
    PH_REL  = 3'd4
  } cfg_phase_e;

  typedef enum logic {
    DIR_WR = 1'b0,
    DIR_RD = 1'b1
  } cfg_dir_e;
endpackage

// File: rtl/cfg_req_bank.sv
module cfg_req_bank
  import psram_cfg_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_i,
  input  logic [NUM_SLOTS-1:0] wr_set_i,
  input  logic [NUM_SLOTS-1:0] rd_set_i,
  input  logic                 clr_valid_i,
  input  logic [SLOT_W-1:0]    clr_slot_i,
  input  cfg_dir_e             clr_dir_i,
  output logic [NUM_SLOTS-1:0] wr_pend_o,
  output logic [NUM_SLOTS-1:0] rd_pend_o,
  output logic                 pick_valid_o,
  output logic [SLOT_W-1:0]    pick_slot_o,
  output cfg_dir_e             pick_dir_o
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam logic [SLOT_W-1:0] IDX = SLOT_W'(g);
    logic clr_here;
    assign clr_here = clr_valid_i && (clr_slot_i == IDX);

    always_ff @(posedge clk) begin
      if (rst) begin
        wr_pend_o[g] <= 1'b0;
        rd_pend_o[g] <= 1'b0;
      end else begin
        if (clr_here && clr_dir_i == DIR_WR) wr_pend_o[g] <= 1'b0;
        if (clr_here && clr_dir_i == DIR_RD) rd_pend_o[g] <= 1'b0;
        if (mode_i && wr_set_i[g]) wr_pend_o[g] <= 1'b1;
        if (mode_i && rd_set_i[g]) rd_pend_o[g] <= 1'b1;
      end
    end
  end

  // lowest slot wins; write before read inside a slot
  always_comb begin
    pick_valid_o = 1'b0;
    pick_slot_o  = '0;
    pick_dir_o   = DIR_WR;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (wr_pend_o[i] || rd_pend_o[i]) begin
        pick_valid_o = 1'b1;
        pick_slot_o  = SLOT_W'(i);
        pick_dir_o   = wr_pend_o[i] ? DIR_WR : DIR_RD;
      end
    end
  end

  assert_mode_gate_R2: assert property (@(posedge clk) disable iff (rst)
    !mode_i |=> (((wr_pend_o & ~$past(wr_pend_o)) == '0) &&
                 ((rd_pend_o & ~$past(rd_pend_o)) == '0)));

  assert_clear_on_finish_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_valid_i && clr_dir_i == DIR_WR && !(mode_i && wr_set_i[clr_slot_i]))
      |=> !wr_pend_o[$past(clr_slot_i)]);

endmodule

// File: rtl/cfg_hold_reg.sv
module cfg_hold_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic [DATA_W-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else if (cap_i) begin
      q_o <= cap_data_i;
    end else if (wr_en_i && !busy_i) begin
      q_o <= wr_data_i;
    end
  end

  assert_frozen_while_busy_R12: assert property (@(posedge clk) disable iff (rst)
    (busy_i && !cap_i) |=> $stable(q_o));

  assert_capture_value_R7: assert property (@(posedge clk) disable iff (rst)
    cap_i |=> (q_o == $past(cap_data_i)));

endmodule

// File: rtl/cfg_bus_fsm.sv
module cfg_bus_fsm
  import psram_cfg_pkg::*;
#(
  parameter int                NUM_SLOTS = 4,
  parameter int                DATA_W    = 16,
  parameter int                DATA_CYC  = 2,
  parameter logic [DATA_W-1:0] CFG_ADDR  = 16'h0080,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CNT_W  = (DATA_CYC > 1) ? $clog2(DATA_CYC) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pick_valid_i,
  input  logic [SLOT_W-1:0]    pick_slot_i,
  input  cfg_dir_e             pick_dir_i,
  input  logic [DATA_W-1:0]    hold_i,
  output cfg_phase_e           phase_o,
  output logic                 fin_o,
  output logic [SLOT_W-1:0]    fin_slot_o,
  output cfg_dir_e             fin_dir_o,
  output logic                 done_o,
  output logic [DATA_W-1:0]    bus_ad_o,
  output logic                 bus_ad_oe_o,
  output logic                 bus_ale_o,
  output logic                 bus_rd_n_o,
  output logic                 bus_wr_n_o,
  output logic [NUM_SLOTS-1:0] bus_cs_n_o,
  output logic                 bus_cre_o
);

  cfg_phase_e          st_q, st_n;
  logic [SLOT_W-1:0]   slot_q, slot_n;
  cfg_dir_e            dir_q, dir_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic                act_n;

  always_comb begin
    st_n   = st_q;
    slot_n = slot_q;
    dir_n  = dir_q;
    cnt_n  = cnt_q;
    fin_o  = 1'b0;
    unique case (st_q)
      PH_IDLE: if (pick_valid_i) begin
        st_n   = PH_ADDR;
        slot_n = pick_slot_i;
        dir_n  = pick_dir_i;
      end
      PH_ADDR: st_n = PH_TURN;
      PH_TURN: begin
        st_n  = PH_DATA;
        cnt_n = '0;
      end
      PH_DATA: begin
        if (cnt_q == CNT_W'(DATA_CYC - 1)) begin
          st_n  = PH_REL;
          fin_o = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      PH_REL:  st_n = PH_IDLE;
      default: st_n = PH_IDLE;
    endcase
  end

  assign act_n      = (st_n == PH_ADDR) || (st_n == PH_TURN) || (st_n == PH_DATA);
  assign phase_o    = st_q;
  assign fin_slot_o = slot_q;
  assign fin_dir_o  = dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= PH_IDLE;
      slot_q      <= '0;
      dir_q       <= DIR_WR;
      cnt_q       <= '0;
      done_o      <= 1'b0;
      bus_ad_o    <= '0;
      bus_ad_oe_o <= 1'b0;
      bus_ale_o   <= 1'b0;
      bus_rd_n_o  <= 1'b1;
      bus_wr_n_o  <= 1'b1;
      bus_cre_o   <= 1'b0;
    end else begin
      st_q        <= st_n;
      slot_q      <= slot_n;
      dir_q       <= dir_n;
      cnt_q       <= cnt_n;
      done_o      <= fin_o;
      bus_cre_o   <= act_n;
      bus_ale_o   <= (st_n == PH_ADDR);
      bus_ad_oe_o <= (st_n == PH_ADDR) || (st_n == PH_DATA && dir_n == DIR_WR);
      bus_wr_n_o  <= !(st_n == PH_DATA && dir_n == DIR_WR);
      bus_rd_n_o  <= !(st_n == PH_DATA && dir_n == DIR_RD);
      if (st_n == PH_ADDR)
        bus_ad_o <= CFG_ADDR;
      else if (st_n == PH_DATA && dir_n == DIR_WR)
        bus_ad_o <= hold_i;
      else
        bus_ad_o <= '0;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cs
    localparam logic [SLOT_W-1:0] IDX = SLOT_W'(g);
    always_ff @(posedge clk) begin
      if (rst) bus_cs_n_o[g] <= 1'b1;
      else     bus_cs_n_o[g] <= !(act_n && slot_n == IDX);
    end
  end

  assert_single_cs_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n_o));

  assert_cre_tracks_cs_R4: assert property (@(posedge clk) disable iff (rst)
    bus_cre_o == (bus_cs_n_o != '1));

  assert_turnaround_after_ale_R5: assert property (@(posedge clk) disable iff (rst)
    bus_ale_o |=> (!bus_ale_o && !bus_ad_oe_o && bus_cre_o && bus_rd_n_o && bus_wr_n_o));

  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n_o && !bus_wr_n_o));

  assert_done_in_release_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (bus_cs_n_o == '1 && !bus_cre_o && bus_rd_n_o && bus_wr_n_o));

endmodule

// File: rtl/psram_cfg_seq.sv
module psram_cfg_seq
  import psram_cfg_pkg::*;
#(
  parameter int                NUM_SLOTS = 4,
  parameter int                DATA_W    = 16,
  parameter int                DATA_CYC  = 2,
  parameter logic [DATA_W-1:0] CFG_ADDR  = 16'h0080
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mux_mode_i,
  input  logic                 hold_we_i,
  input  logic [DATA_W-1:0]    hold_wdata_i,
  output logic [DATA_W-1:0]    hold_o,
  input  logic [NUM_SLOTS-1:0] wr_req_set_i,
  input  logic [NUM_SLOTS-1:0] rd_req_set_i,
  output logic [NUM_SLOTS-1:0] wr_pend_o,
  output logic [NUM_SLOTS-1:0] rd_pend_o,
  output logic                 busy_o,
  output logic                 done_o,
  input  logic                 sys_req_i,
  output logic                 sys_gnt_o,
  output logic [DATA_W-1:0]    bus_ad_o,
  output logic                 bus_ad_oe_o,
  input  logic [DATA_W-1:0]    bus_ad_i,
  output logic                 bus_ale_o,
  output logic                 bus_rd_n_o,
  output logic                 bus_wr_n_o,
  output logic [NUM_SLOTS-1:0] bus_cs_n_o,
  output logic                 bus_cre_o
);

  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic              pick_valid;
  logic [SLOT_W-1:0] pick_slot;
  cfg_dir_e          pick_dir;
  logic              fin;
  logic [SLOT_W-1:0] fin_slot;
  cfg_dir_e          fin_dir;
  cfg_phase_e        phase;

  cfg_req_bank #(.NUM_SLOTS(NUM_SLOTS)) u_req (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mux_mode_i),
    .wr_set_i     (wr_req_set_i),
    .rd_set_i     (rd_req_set_i),
    .clr_valid_i  (fin),
    .clr_slot_i   (fin_slot),
    .clr_dir_i    (fin_dir),
    .wr_pend_o    (wr_pend_o),
    .rd_pend_o    (rd_pend_o),
    .pick_valid_o (pick_valid),
    .pick_slot_o  (pick_slot),
    .pick_dir_o   (pick_dir)
  );

  cfg_bus_fsm #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W),
    .DATA_CYC  (DATA_CYC),
    .CFG_ADDR  (CFG_ADDR)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .pick_valid_i (pick_valid),
    .pick_slot_i  (pick_slot),
    .pick_dir_i   (pick_dir),
    .hold_i       (hold_o),
    .phase_o      (phase),
    .fin_o        (fin),
    .fin_slot_o   (fin_slot),
    .fin_dir_o    (fin_dir),
    .done_o       (done_o),
    .bus_ad_o     (bus_ad_o),
    .bus_ad_oe_o  (bus_ad_oe_o),
    .bus_ale_o    (bus_ale_o),
    .bus_rd_n_o   (bus_rd_n_o),
    .bus_wr_n_o   (bus_wr_n_o),
    .bus_cs_n_o   (bus_cs_n_o),
    .bus_cre_o    (bus_cre_o)
  );

  cfg_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (hold_we_i),
    .wr_data_i  (hold_wdata_i),
    .busy_i     (busy_o),
    .cap_i      (fin && fin_dir == DIR_RD),
    .cap_data_i (bus_ad_i),
    .q_o        (hold_o)
  );

  assign busy_o    = (phase != PH_IDLE) || (|wr_pend_o) || (|rd_pend_o);
  assign sys_gnt_o = sys_req_i && !busy_o;

  assert_busy_while_cs_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_cs_n_o != '1) |-> busy_o);

  assert_no_grant_on_bus_R11: assert property (@(posedge clk) disable iff (rst)
    bus_cre_o |-> !sys_gnt_o);

endmodule

// File: tb/psram_cfg_seq_tb.sv
module psram_cfg_seq_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          NS  = 4;
  localparam int          DW  = 16;
  localparam int          DC  = 2;
  localparam logic [15:0] CAD = 16'h0080;

  logic          clk = 1'b0;
  logic          rst, mux_mode, hold_we, sys_req;
  logic [DW-1:0] hold_wdata, ad_in = 16'h3C01;
  logic [NS-1:0] wr_set, rd_set;
  logic [DW-1:0] hold_q, ad_out;
  logic [NS-1:0] wr_pend, rd_pend, cs_n;
  logic          busy, done, gnt, ad_oe, ale, rd_n, wr_n, cre;

  psram_cfg_seq #(.NUM_SLOTS(NS), .DATA_W(DW), .DATA_CYC(DC), .CFG_ADDR(CAD)) dut_i (
    .clk(clk), .rst(rst), .mux_mode_i(mux_mode), .hold_we_i(hold_we),
    .hold_wdata_i(hold_wdata), .hold_o(hold_q), .wr_req_set_i(wr_set),
    .rd_req_set_i(rd_set), .wr_pend_o(wr_pend), .rd_pend_o(rd_pend),
    .busy_o(busy), .done_o(done), .sys_req_i(sys_req), .sys_gnt_o(gnt),
    .bus_ad_o(ad_out), .bus_ad_oe_o(ad_oe), .bus_ad_i(ad_in), .bus_ale_o(ale),
    .bus_rd_n_o(rd_n), .bus_wr_n_o(wr_n), .bus_cs_n_o(cs_n), .bus_cre_o(cre));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: phase 0 idle, 1 addr, 2 turn, 3 data, 4 release
  int            m_phase = 0, m_cnt = 0, m_slot = 0;
  bit            m_rd = 0, m_done = 0;
  logic [NS-1:0] m_w = '0, m_r = '0;
  logic [DW-1:0] m_hold = '0;
  int            vectors = 0, miscompares = 0, cycles = 0;
  bit            ended = 0;

  always @(posedge clk) begin
    bit busy_pre, fin;
    if (rst) begin
      m_phase = 0; m_cnt = 0; m_w = '0; m_r = '0; m_hold = '0; m_done = 0;
    end else begin
      busy_pre = (m_phase != 0) || (m_w != 0) || (m_r != 0);
      fin = 0;
      case (m_phase)
        0: begin
          for (int i = 0; i < NS; i++) begin
            if (m_phase == 0 && (m_w[i] || m_r[i])) begin
              m_phase = 1; m_slot = i; m_rd = !m_w[i];
            end
          end
        end
        1: m_phase = 2;
        2: begin m_phase = 3; m_cnt = 0; end
        3: if (m_cnt == DC - 1) begin fin = 1; m_phase = 4; end else m_cnt++;
        default: m_phase = 0;
      endcase
      if (fin) begin
        if (m_rd) begin m_hold = ad_in; m_r[m_slot] = 1'b0; end
        else m_w[m_slot] = 1'b0;
      end else if (hold_we && !busy_pre) m_hold = hold_wdata;
      if (mux_mode) begin m_w |= wr_set; m_r |= rd_set; end
      m_done = fin;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [NS-1:0] e_cs;
    bit act, e_busy;
    if (!ended) begin
      vectors++;
      act = (m_phase >= 1 && m_phase <= 3);
      e_cs = '1;
      if (act) e_cs[m_slot] = 1'b0;
      e_busy = (m_phase != 0) || (m_w != 0) || (m_r != 0);
      chk(rst ? "R1" : "R3", "cs_n", 32'(cs_n), 32'(e_cs));
      chk(rst ? "R1" : "R4", "cre", 32'(cre), 32'(act));
      chk(rst ? "R1" : "R5", "ale", 32'(ale), 32'(m_phase == 1));
      chk(rst ? "R1" : "R5", "ad_oe", 32'(ad_oe), 32'((m_phase == 1) || (m_phase == 3 && !m_rd)));
      chk(rst ? "R1" : "R5", "wr_n", 32'(wr_n), 32'(!(m_phase == 3 && !m_rd)));
      chk(rst ? "R1" : "R5", "rd_n", 32'(rd_n), 32'(!(m_phase == 3 && m_rd)));
      if (m_phase == 1) chk("R5", "addr", 32'(ad_out), 32'(CAD));
      if (m_phase == 3 && !m_rd) chk("R6", "wdata", 32'(ad_out), 32'(m_hold));
      chk(rst ? "R1" : "R10", "busy", 32'(busy), 32'(e_busy));
      chk(rst ? "R1" : "R8", "done", 32'(done), 32'(m_done));
      chk(rst ? "R1" : "R7_R12", "hold", 32'(hold_q), 32'(m_hold));
      chk(rst ? "R1" : "R9_R2", "wr_pend", 32'(wr_pend), 32'(m_w));
      chk(rst ? "R1" : "R9_R2", "rd_pend", 32'(rd_pend), 32'(m_r));
      chk("R11", "sys_gnt", 32'(gnt), 32'(sys_req && !e_busy));
    end
  end

  // read data changes every cycle so the capture edge is pinned down (R7)
  always @(negedge clk) begin
    #1 ad_in <= ad_in + 16'h0111;
  end

  task automatic finish_run();
    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !ended) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200; k++) begin
      tick();
      if (m_phase == 0 && m_w == 0 && m_r == 0) break;
    end
    tick();
  endtask

  initial begin
    rst = 1; mux_mode = 0; hold_we = 0; sys_req = 0;
    hold_wdata = '0; wr_set = '0; rd_set = '0;
    repeat (3) tick();
    rst = 0;
    tick();
    // R6: single write on slot 0
    hold_we = 1; hold_wdata = 16'h1234; tick(); hold_we = 0;
    mux_mode = 1; wr_set = 4'b0001; tick(); wr_set = '0;
    wait_idle();
    // R7: single read on slot 2
    rd_set = 4'b0100; tick(); rd_set = '0;
    wait_idle();
    // R9: four requests at once, plus R12 / R11 stimulus while busy
    wr_set = 4'b1010; rd_set = 4'b0011; tick(); wr_set = '0; rd_set = '0;
    hold_we = 1; hold_wdata = 16'hDEAD; sys_req = 1; tick(); hold_we = 0;
    repeat (3) tick();
    wait_idle();
    tick(); sys_req = 0;
    // R2: requests outside multiplexed mode
    mux_mode = 0; wr_set = 4'hF; rd_set = 4'hF; tick(); wr_set = '0; rd_set = '0;
    repeat (4) tick();
    mux_mode = 1;
    // write back captured value on slot 3, then late lower-slot request
    wr_set = 4'b1000; tick(); wr_set = '0;
    tick();
    rd_set = 4'b0010; tick(); rd_set = '0;
    wr_set = 4'b0001; tick(); wr_set = '0;
    wait_idle();
    hold_we = 1; hold_wdata = 16'h5A5A; tick(); hold_we = 0;
    rd_set = 4'b0001; tick(); rd_set = '0;
    wait_idle();
    repeat (2) tick();
    finish_run();
  end
endmodule